// File: doc/BRIEF.md
# Lockable System Control Register Bank

This block is a bank of 32-bit control and status words reached through a plain word-addressed bus. The bus has separate read and write strobes and a byte address. Most of the lower part of the map is guarded by a lock. While the lock is engaged, software can change those words only after it writes a fixed unlock constant to the key word at offset 0x00. Words at offset 0x100 and above are never guarded.

At reset the bank loads a table of default values, chosen by a revision parameter. The revision identifier and the two strap words come from input pins. The lock state also comes from a pin, so the bank can leave reset already open.

A few offsets do not behave as plain storage:
- Some words are read-only and ignore writes.
- One offset returns a fresh pseudo-random word on every read.
- Under the newer revision, the strap word only accumulates bits, and a write aimed at the revision-ID offset clears strap bits instead.

Read data is registered. A one-cycle error pulse flags every write that was refused.

Top module: `sysctl_regbank`

## Requirements
- R1: The word index is the byte address shifted right by two. An access whose address bits [1:0] are not zero, or whose index is NUM_REGS or more, is out of range: a read returns 0, and a write changes nothing and raises the error pulse.
- R2: A write to offset 0x00 stores 1 when the data equals UNLOCK_KEY and stores 0 otherwise. This offset is writable whether the bank is locked or not, and reading it returns that 0 or 1.
- R3: While offset 0x00 holds 0, writes to offsets 0x04 through 0xFC change nothing and raise the error pulse. Offsets at 0x100 and above accept writes whatever the lock state.
- R4: Reset has the following effects:
  - Offset 0x00 takes the value of boot_unlocked.
  - Offset 0x7C loads from rev_id_in, 0x70 from strap_main_in and 0xD0 from strap_aux_in.
  - The other words take the per-revision defaults. Examples: 0x04 = 0xFFCFFEDC and 0x08 = 0xF3F40000 in both revisions; 0x24 = 0x93000400 in the newer revision and 0x00000291 in the older; 0x8C = 0x000000FF in the older revision.
- R5: Writes to offsets 0x14, 0x50 through 0x6C, 0x78, 0xE0 and 0xE4 change nothing and raise the error pulse.
- R6: With NEWER_REV=1, a write to 0x70 ORs the data into the stored strap word. With NEWER_REV=0, the same write replaces the word.
- R7: Offset 0x7C is never modified. With NEWER_REV=1, a write to 0x7C clears the bits of the 0x70 strap word that are 1 in the data, and raises no error. With NEWER_REV=0, such a write changes nothing and raises the error pulse.
- R8: Each read of 0x78 advances a 32-bit Galois LFSR one step and returns the new state. The LFSR starts at LFSR_SEED and takes one step as next = (s >> 1) ^ (s[0] ? 0x80200003 : 0). This happens regardless of the contents of 0x74.
- R9: Timing of the outputs:
  - rdata takes its new value on the clock edge that samples rd_en and holds it until the next read.
  - err is high for exactly the one cycle after a refused write, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_unlocked | input | 1 | Lock state loaded at reset (1 = open) |
| rev_id_in | input | 32 | Revision identifier loaded into 0x7C at reset |
| strap_main_in | input | 32 | Strap word loaded into 0x70 at reset |
| strap_aux_in | input | 32 | Second strap word loaded into 0xD0 at reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle pulse for a refused write |

## Verification
The bench builds two copies of the bank, both with the default NUM_REGS of 106 and ADDR_W of 12:
- The first copy uses NEWER_REV=1 and leaves reset locked. This covers the unlock sequence, the accumulate-only strap word with its clearing alias, and relocking.
- The second copy uses NEWER_REV=0 and leaves reset open. This covers the replacing strap write, the refused revision-ID write and the older default table.

The 12-bit address reaches far past the last implemented word, up to 0xFFC, so out-of-range reads and writes are exercised alongside misaligned ones. Both copies share the default LFSR seed, so one bench model of the LFSR predicts the random words of both copies.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DATA_W        = 32;
    localparam int IDX_KEY       = 0;
    localparam int IDX_STRAP     = 28;   // byte offset 0x70
    localparam int IDX_RANDOM    = 30;   // byte offset 0x78
    localparam int IDX_REVID     = 31;   // byte offset 0x7C
    localparam int IDX_STRAP_AUX = 52;   // byte offset 0xD0
    localparam int GUARD_END     = 64;   // first unguarded index (0x100)
    localparam logic [DATA_W-1:0] LFSR_TAPS = 32'h8020_0003;

    typedef enum logic [2:0] {
        RK_PLAIN,
        RK_KEY,
        RK_RDONLY,
        RK_RANDOM,
        RK_STRAP,
        RK_REVID
    } reg_kind_e;

    typedef struct packed {
        logic      valid;    // aligned and inside the bank
        logic      guarded;  // subject to the lock
        reg_kind_e kind;
    } decode_t;

    function automatic reg_kind_e kind_of(input int idx);
        case (idx)
            IDX_KEY:                     return RK_KEY;
            IDX_STRAP:                   return RK_STRAP;
            IDX_REVID:                   return RK_REVID;
            IDX_RANDOM:                  return RK_RANDOM;
            5, 20, 21, 22, 23, 24, 25,
            26, 27, 56, 57:              return RK_RDONLY;
            default:                     return RK_PLAIN;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] default_word(input int idx, input bit newer);
        case (idx)
            1:   return 32'hFFCF_FEDC;
            2:   return 32'hF3F4_0000;
            3:   return 32'h19FC_3E8B;
            7:   return 32'h0002_6108;
            8:   return 32'h0003_0291;
            9:   return newer ? 32'h9300_0400 : 32'h0000_0291;
            11:  return 32'h0000_0010;
            12:  return 32'h2000_1A03;
            13:  return 32'h2000_1A03;
            14:  return 32'h0400_0030;
            15:  return 32'h0000_0001;
            16:  return 32'h0000_00C0;
            19:  return 32'h0000_0023;
            29:  return 32'h0000_000E;
            33:  return 32'h0000_F000;
            34:  return newer ? 32'h0300_0000 : 32'h0100_0000;
            35:  return newer ? 32'h0000_0000 : 32'h0000_00FF;
            36:  return 32'h0000_A000;
            39:  return newer ? 32'h023F_FFF3 : 32'h003F_FFF3;
            41:  return 32'hFFFF_0000;
            42:  return 32'h000F_FFFF;
            56:  return 32'h0000_00FF;
            57:  return 32'h0000_00FF;
            65:  return 32'h8000_0000;
            68:  return 32'h1E60_0000;
            69:  return 32'hC000_0000;
            88:  return 32'h0000_1903;
            96:  return 32'h0000_007B;
            105: return 32'h0000_2402;
            default: return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] lfsr_advance(input logic [DATA_W-1:0] s);
        return {1'b0, s[DATA_W-1:1]} ^ (s[0] ? LFSR_TAPS : '0);
    endfunction

endpackage

// File: rtl/sysctl_addr_decode.sv
module sysctl_addr_decode
    import sysctl_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NUM_REGS = 106,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output decode_t           info
);
    localparam int FULL_W = ADDR_W - 2;

    logic [FULL_W-1:0] idx_full;

    always_comb begin
        idx_full     = addr[ADDR_W-1:2];
        idx          = idx_full[IDX_W-1:0];
        info.valid   = (addr[1:0] == 2'b00) && (int'(idx_full) < NUM_REGS);
        info.guarded = (int'(idx_full) >= 1) && (int'(idx_full) < GUARD_END);
        info.kind    = kind_of(int'(idx_full));
    end
endmodule

// File: rtl/sysctl_lfsr.sv
module sysctl_lfsr
    import sysctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] SEED = 32'hC0FF_EE01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [DATA_W-1:0] next_value
);
    logic [DATA_W-1:0] state_q;

    assign next_value = lfsr_advance(state_q);

    always_ff @(posedge clk) begin
        if (rst)       state_q <= SEED;
        else if (step) state_q <= next_value;
    end
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter int                NUM_REGS   = 106,
    parameter bit                NEWER_REV  = 1'b1,
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1688_A8A8,
    parameter logic [DATA_W-1:0] LFSR_SEED  = 32'hC0FF_EE01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_unlocked,
    input  logic [31:0]       rev_id_in,
    input  logic [31:0]       strap_main_in,
    input  logic [31:0]       strap_aux_in,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              err
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic [DATA_W-1:0] bank_q [NUM_REGS];
    logic [IDX_W-1:0]  idx;
    decode_t           info;
    logic [DATA_W-1:0] rand_word;
    logic [DATA_W-1:0] strap_cur;
    logic [DATA_W-1:0] revid_cur;
    logic              unlocked;
    logic              refused;
    logic              wr_commit;
    logic [IDX_W-1:0]  tgt_idx;
    logic [DATA_W-1:0] wr_value;
    logic              rand_step;

    sysctl_addr_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_REGS(NUM_REGS),
        .IDX_W   (IDX_W)
    ) u_decode (
        .addr(addr),
        .idx (idx),
        .info(info)
    );

    assign rand_step = rd_en && info.valid && (info.kind == RK_RANDOM);

    sysctl_lfsr #(.SEED(LFSR_SEED)) u_lfsr (
        .clk       (clk),
        .rst       (rst),
        .step      (rand_step),
        .next_value(rand_word)
    );

    assign unlocked  = bank_q[IDX_KEY][0];
    assign strap_cur = bank_q[IDX_STRAP];
    assign revid_cur = bank_q[IDX_REVID];

    // Write qualification: lock, read-only kinds and the old-revision alias.
    always_comb begin
        refused = !info.valid
               || (info.guarded && !unlocked)
               || (info.kind == RK_RDONLY)
               || (info.kind == RK_RANDOM)
               || ((info.kind == RK_REVID) && !NEWER_REV);
        wr_commit = wr_en && !refused;
        tgt_idx   = (info.kind == RK_REVID) ? IDX_W'(IDX_STRAP) : idx;
        case (info.kind)
            RK_KEY:   wr_value = {{(DATA_W-1){1'b0}}, (wdata == UNLOCK_KEY)};
            RK_STRAP: wr_value = NEWER_REV ? (strap_cur | wdata) : wdata;
            RK_REVID: wr_value = strap_cur & ~wdata;
            default:  wr_value = wdata;
        endcase
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        logic [DATA_W-1:0] init_val;
        if (g == IDX_KEY) begin : g_key
            assign init_val = {{(DATA_W-1){1'b0}}, boot_unlocked};
        end else if (g == IDX_STRAP) begin : g_strap
            assign init_val = strap_main_in;
        end else if (g == IDX_REVID) begin : g_rev
            assign init_val = rev_id_in;
        end else if (g == IDX_STRAP_AUX) begin : g_aux
            assign init_val = strap_aux_in;
        end else begin : g_tbl
            assign init_val = default_word(g, NEWER_REV);
        end

        always_ff @(posedge clk) begin
            if (rst)
                bank_q[g] <= init_val;
            else if (wr_commit && (tgt_idx == IDX_W'(g)))
                bank_q[g] <= wr_value;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            err <= wr_en && refused;
            if (rd_en) begin
                if (!info.valid)                 rdata <= '0;
                else if (info.kind == RK_RANDOM) rdata <= rand_word;
                else                             rdata <= bank_q[idx];
            end
        end
    end
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
    parameter int          ADDR_W     = 12,
    parameter int          NUM_REGS   = 106,
    parameter bit          NEWER_REV  = 1'b1,
    parameter logic [31:0] UNLOCK_KEY = 32'h1688_A8A8
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              err,
    input logic              unlocked,
    input logic [31:0]       strap_cur,
    input logic [31:0]       revid_cur
);
    logic out_of_range;
    logic in_guard;
    assign out_of_range = (addr[1:0] != 2'b00) || (int'(addr >> 2) >= NUM_REGS);
    assign in_guard     = (int'(addr) >= 4) && (int'(addr) < 'h100);

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_en && out_of_range |=> rdata == 32'h0); // R1

    AST_KEY_STORES_MATCH: assert property (@(posedge clk) disable iff (rst)
        wr_en && (addr == '0) |=> unlocked == ($past(wdata) == UNLOCK_KEY)); // R2

    AST_LOCKED_WRITE_ERR: assert property (@(posedge clk) disable iff (rst)
        wr_en && !unlocked && in_guard |=> err); // R3

    AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(wr_en)); // R9

    AST_REVID_FIXED: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(revid_cur)); // R7

    AST_STRAP_ONLY_GROWS: assert property (@(posedge clk) disable iff (rst)
        NEWER_REV && !$past(rst) && !($past(wr_en) && ($past(addr) == ADDR_W'('h7C)))
        |-> (($past(strap_cur) & ~strap_cur) == 32'h0)); // R6
endmodule

bind sysctl_regbank sysctl_regbank_chk #(
    .ADDR_W    (ADDR_W),
    .NUM_REGS  (NUM_REGS),
    .NEWER_REV (NEWER_REV),
    .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .err      (err),
    .unlocked (unlocked),
    .strap_cur(strap_cur),
    .revid_cur(revid_cur)
);

// File: tb/test_sysctl_regbank.sv
module test_sysctl_regbank;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] KEY        = 32'h1688_A8A8;
    localparam logic [31:0] SEED       = 32'hC0FF_EE01;
    localparam logic [31:0] N_REV      = 32'h0400_0303;
    localparam logic [31:0] N_STRAP    = 32'h0000_00F0;
    localparam logic [31:0] N_AUX      = 32'h0000_0011;
    localparam logic [31:0] L_REV      = 32'h0200_0303;
    localparam logic [31:0] L_STRAP    = 32'h0000_00A0;
    localparam logic [31:0] L_AUX      = 32'h0000_0022;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        n_rd = 0, n_wr = 0, l_rd = 0, l_wr = 0;
    logic [11:0] n_addr = 0, l_addr = 0;
    logic [31:0] n_wdata = 0, l_wdata = 0;
    logic [31:0] n_rdata, l_rdata;
    logic        n_err, l_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    sysctl_regbank #(.NEWER_REV(1'b1)) i_sysctl_regbank (
        .clk(clk), .rst(rst), .boot_unlocked(1'b0),
        .rev_id_in(N_REV), .strap_main_in(N_STRAP), .strap_aux_in(N_AUX),
        .rd_en(n_rd), .wr_en(n_wr), .addr(n_addr), .wdata(n_wdata),
        .rdata(n_rdata), .err(n_err)
    );

    sysctl_regbank #(.NEWER_REV(1'b0)) i_sysctl_regbank_legacy (
        .clk(clk), .rst(rst), .boot_unlocked(1'b1),
        .rev_id_in(L_REV), .strap_main_in(L_STRAP), .strap_aux_in(L_AUX),
        .rd_en(l_rd), .wr_en(l_wr), .addr(l_addr), .wdata(l_wdata),
        .rdata(l_rdata), .err(l_err)
    );

    function automatic logic [31:0] model_step(input logic [31:0] s);
        logic [31:0] t = s >> 1;
        if (s[0]) t = t ^ 32'h8020_0003;
        return t;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // One bus access; results sampled on the falling edge after the capturing edge.
    task automatic access(input bit leg, input bit wr, input logic [11:0] a,
                          input logic [31:0] d, output logic [31:0] rd, output logic e);
        @(negedge clk);
        if (leg) begin l_addr = a; l_wdata = d; l_wr = wr; l_rd = !wr; end
        else     begin n_addr = a; n_wdata = d; n_wr = wr; n_rd = !wr; end
        @(negedge clk);
        rd = leg ? l_rdata : n_rdata;
        e  = leg ? l_err   : n_err;
        n_wr = 0; n_rd = 0; l_wr = 0; l_rd = 0;
    endtask

    task automatic rd_chk(input bit leg, input logic [11:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v; logic e;
        access(leg, 1'b0, a, '0, v, e);
        check(req, v, exp);
    endtask

    task automatic wr_chk(input bit leg, input logic [11:0] a, input logic [31:0] d,
                          input logic exp_err, input string req);
        logic [31:0] v; logic e;
        access(leg, 1'b1, a, d, v, e);
        check(req, {31'b0, e}, {31'b0, exp_err});
    endtask

    task automatic t_reset;
        check("R9 reset rdata", n_rdata, 32'h0);
        check("R9 reset err", {31'b0, n_err}, 32'h0);
        rd_chk(0, 12'h000, 32'h0,         "R4 newer key boots locked");
        rd_chk(0, 12'h004, 32'hFFCF_FEDC, "R4 default 0x04");
        @(negedge clk);
        check("R9 rdata held", n_rdata, 32'hFFCF_FEDC);
        check("R9 err idle", {31'b0, n_err}, 32'h0);
        rd_chk(0, 12'h008, 32'hF3F4_0000, "R4 default 0x08");
        rd_chk(0, 12'h024, 32'h9300_0400, "R4 newer default 0x24");
        rd_chk(0, 12'h07C, N_REV,         "R4 revid pin");
        rd_chk(0, 12'h070, N_STRAP,       "R4 strap pin");
        rd_chk(0, 12'h0D0, N_AUX,         "R4 aux strap pin");
        rd_chk(1, 12'h000, 32'h1,         "R4 legacy key boots open");
        rd_chk(1, 12'h024, 32'h0000_0291, "R4 legacy default 0x24");
        rd_chk(1, 12'h08C, 32'h0000_00FF, "R4 legacy default 0x8C");
    endtask

    task automatic t_locked;
        wr_chk(0, 12'h008, 32'h1234_5678, 1'b1, "R3 locked write err");
        rd_chk(0, 12'h008, 32'hF3F4_0000,        "R3 locked write discarded");
        wr_chk(0, 12'h070, 32'h0000_F000, 1'b1, "R3 locked strap err");
        rd_chk(0, 12'h070, N_STRAP,              "R3 locked strap unchanged");
        wr_chk(0, 12'h104, 32'hA5A5_0001, 1'b0, "R3 high offset open");
        rd_chk(0, 12'h104, 32'hA5A5_0001,        "R3 high offset stored");
    endtask

    task automatic t_key;
        wr_chk(0, 12'h000, KEY ^ 32'h1, 1'b0, "R2 wrong key no err");
        rd_chk(0, 12'h000, 32'h0,              "R2 wrong key stores 0");
        wr_chk(0, 12'h000, KEY, 1'b0,          "R2 key write");
        rd_chk(0, 12'h000, 32'h1,              "R2 right key stores 1");
        wr_chk(0, 12'h008, 32'h1234_5678, 1'b0, "R3 unlocked write ok");
        rd_chk(0, 12'h008, 32'h1234_5678,        "R3 unlocked write stored");
    endtask

    task automatic t_readonly;
        wr_chk(0, 12'h014, 32'hFFFF_FFFF, 1'b1, "R5 0x14 err");
        rd_chk(0, 12'h014, 32'h0,                "R5 0x14 unchanged");
        wr_chk(0, 12'h050, 32'hFFFF_FFFF, 1'b1, "R5 0x50 err");
        wr_chk(0, 12'h06C, 32'hFFFF_FFFF, 1'b1, "R5 0x6C err");
        rd_chk(0, 12'h06C, 32'h0,                "R5 0x6C unchanged");
        wr_chk(0, 12'h0E4, 32'h0,         1'b1, "R5 0xE4 err");
        rd_chk(0, 12'h0E4, 32'h0000_00FF,        "R5 0xE4 unchanged");
        wr_chk(0, 12'h0E0, 32'h0,         1'b1, "R5 0xE0 err");
    endtask

    task automatic t_random;
        logic [31:0] s = SEED;
        wr_chk(0, 12'h074, 32'h0, 1'b0, "R8 random control cleared");
        wr_chk(0, 12'h078, 32'h0, 1'b1, "R5 0x78 write err");
        for (int i = 0; i < 3; i++) begin
            s = model_step(s);
            rd_chk(0, 12'h078, s, "R8 newer random sequence");
        end
        rd_chk(1, 12'h078, model_step(SEED), "R8 legacy first random");
    endtask

    task automatic t_strap_newer;
        wr_chk(0, 12'h070, 32'h0000_0F00, 1'b0, "R6 or-write no err");
        rd_chk(0, 12'h070, 32'h0000_0FF0,        "R6 strap accumulates");
        wr_chk(0, 12'h07C, 32'h0000_00F0, 1'b0, "R7 alias clear no err");
        rd_chk(0, 12'h070, 32'h0000_0F00,        "R7 alias clears strap bits");
        rd_chk(0, 12'h07C, N_REV,                "R7 revid unchanged");
    endtask

    task automatic t_strap_legacy;
        wr_chk(1, 12'h070, 32'h0000_0005, 1'b0, "R6 legacy strap write");
        rd_chk(1, 12'h070, 32'h0000_0005,        "R6 legacy strap replaced");
        wr_chk(1, 12'h07C, 32'h0000_0005, 1'b1, "R7 legacy revid write err");
        rd_chk(1, 12'h070, 32'h0000_0005,        "R7 legacy strap untouched");
        rd_chk(1, 12'h07C, L_REV,                "R7 legacy revid unchanged");
    endtask

    task automatic t_range;
        rd_chk(0, 12'h1A4, 32'h0000_2402, "R1 last word readable");
        rd_chk(0, 12'h1A8, 32'h0,         "R1 first index past bank reads 0");
        rd_chk(0, 12'hFFC, 32'h0,         "R1 top address reads 0");
        wr_chk(0, 12'h1A8, 32'hDEAD_BEEF, 1'b1, "R1 out-of-range write err");
        rd_chk(0, 12'h006, 32'h0,         "R1 misaligned read 0");
        wr_chk(0, 12'h009, 32'h0, 1'b1,   "R1 misaligned write err");
        rd_chk(0, 12'h008, 32'h1234_5678, "R1 misaligned write no effect");
    endtask

    task automatic t_relock;
        wr_chk(0, 12'h000, 32'h0, 1'b0,   "R2 relock write");
        rd_chk(0, 12'h000, 32'h0,         "R2 relocked");
        wr_chk(0, 12'h008, 32'h0, 1'b1,   "R3 relocked write err");
        rd_chk(0, 12'h008, 32'h1234_5678, "R3 relocked write discarded");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_locked();
        t_key();
        t_readonly();
        t_random();
        t_strap_newer();
        t_strap_legacy();
        t_range();
        t_relock();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule